// File: doc/BRIEF.md
# I2C Master Bus-Fault Supervisor

This block watches the two open-drain lines of an I2C controller and decides whether a start or stop request can go out. Both lines pass through a synchronizer first. Every check uses the synchronized values. The block reports line faults through three sticky flags: start, stop and error. It also shows two live bits that tell whether each line is low right now.

When a start request finds SDA held low, the block does not give up at once. It clocks SCL through a fixed number of pulses and checks SDA after each pulse. If SDA comes free, it issues the START. If SDA stays low after the last pulse, it reports an error. After it sets the start flag, the byte layer takes over the lines.

Timing comes from `tick`, a one-cycle strobe given once per half bit period.

Top module: `i2cfd_top`

## Requirements
- R1: `sda_low` and `scl_low` are the inverted line inputs after a two-flop synchronizer. A change on a line input shows on these bits two clock edges later. After reset both read 0 while the lines are high.
- R2: When `bit_chk` is high while `sda_rel` is high and the synchronized SDA is low, `flag_err` is set on the next edge. When `sda_rel` is low, or SDA is high, `bit_chk` leaves `flag_err` unchanged.
- R3: A pending start with `busy` low and synchronized SCL low does three things on one edge: it sets `flag_err`, sets `flag_start` and clears `start_pending`. Neither line is driven.
- R4: A pending stop with `busy` low and synchronized SCL low does three things on one edge: it sets `flag_err`, sets `flag_stop` and clears `stop_pending`. Neither line is driven.
- R5: While `busy` is high, a latched request stays pending and neither line is driven.
- R6: A start request on an idle bus with both lines high drives SDA low, with SCL released, until the next `tick`. It then sets `flag_start` and clears `start_pending`, without setting `flag_err`.
- R7: A stop request on an idle bus with SCL high drives SDA low for one `tick` interval and then releases it. At that point it sets `flag_stop` and clears `stop_pending`.
- R8: A start request that finds SDA low starts bus clearing. Each SCL pulse drives SCL low until a `tick` and then releases it until the next `tick`, and SDA is checked at the end of the released half. If SDA reads high after pulse N, with N at most 10, the START of R6 follows after exactly N pulses.
- R9: If SDA is still low after the 10th pulse, the block stops pulsing. On that edge it sets `flag_err` and `flag_start` and clears `start_pending`.
- R10: Each flag stays set until its own clear strobe (`clr_start`, `clr_stop`, `clr_err`) is high. A set in the same cycle as a clear wins.
- R11: `soft_rst` returns the block to idle on the next edge. It releases both lines and clears all flags and pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to idle |
| tick | input | 1 | Half-bit-period strobe |
| busy | input | 1 | Bus busy indication |
| start_req | input | 1 | Start request strobe |
| stop_req | input | 1 | Stop request strobe |
| sda_rel | input | 1 | Controller is sending a high bit on SDA |
| bit_chk | input | 1 | Sample point for the high-bit check |
| sda_in | input | 1 | SDA line input |
| scl_in | input | 1 | SCL line input |
| clr_start | input | 1 | Clear strobe for the start flag |
| clr_stop | input | 1 | Clear strobe for the stop flag |
| clr_err | input | 1 | Clear strobe for the error flag |
| sda_oe | output | 1 | Pull SDA low |
| scl_oe | output | 1 | Pull SCL low |
| flag_start | output | 1 | Sticky start flag |
| flag_stop | output | 1 | Sticky stop flag |
| flag_err | output | 1 | Sticky error flag |
| start_pending | output | 1 | Start request not yet served |
| stop_pending | output | 1 | Stop request not yet served |
| sda_low | output | 1 | SDA is low now (synchronized) |
| scl_low | output | 1 | SCL is low now (synchronized) |

## Verification
Some properties are checked on every cycle:
- the results of the SCL-low checks at start and stop,
- flag stickiness and set-over-clear priority,
- the bound on the pulse counter,
- that a busy bus keeps the block idle,
- that the two drive enables are never on together,
- the effect of a soft reset.

The bench scenarios cover what a single property cannot:
- the exact synchronizer latency,
- that a stuck SDA released after 3 or 9 pulses gives exactly that many SCL pulses and then one START,
- that a line that never frees gives exactly 10 pulses and an error.

// File: rtl/i2cfd_pkg.sv
package i2cfd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_STOP,
    ST_CLR_LO,
    ST_CLR_HI
  } fd_state_e;

  localparam int FLG_START = 0;
  localparam int FLG_STOP  = 1;
  localparam int FLG_ERR   = 2;
  localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/i2cfd_sync.sv
module i2cfd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/i2cfd_flags.sv
module i2cfd_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  logic [N-1:0] q_n;

  always_comb begin
    if (soft_rst) q_n = '0;
    else          q_n = (q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  // R10: a set flag survives unless its own clear strobe was high
  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((q | $past(clr)) & $past(q)) == $past(q));

  // R10: a set in the same cycle as a clear wins
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set && !soft_rst) |=> ((q & $past(set)) == $past(set)));

  // R11: soft reset empties every flag
  a_r11_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (q == '0));

endmodule

// File: rtl/i2cfd_pulse_cnt.sv
module i2cfd_pulse_cnt #(
  parameter int MAX = 10,
  localparam int CW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          last
);

  logic [CW-1:0] cnt_n;
  logic          cnt_en;

  assign cnt_en = clr | inc;
  assign last   = (cnt == CW'(MAX - 1));

  always_comb begin
    if (clr) cnt_n = '0;
    else     cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_n;
  end

  // R9: the bus-clear pulse count never exceeds its limit
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX));

endmodule

// File: rtl/i2cfd_top.sv
module i2cfd_top
  import i2cfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLR_PULSES  = 10,
  localparam int CW = $clog2(CLR_PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic tick,
  input  logic busy,
  input  logic start_req,
  input  logic stop_req,
  input  logic sda_rel,
  input  logic bit_chk,
  input  logic sda_in,
  input  logic scl_in,
  input  logic clr_start,
  input  logic clr_stop,
  input  logic clr_err,
  output logic sda_oe,
  output logic scl_oe,
  output logic flag_start,
  output logic flag_stop,
  output logic flag_err,
  output logic start_pending,
  output logic stop_pending,
  output logic sda_low,
  output logic scl_low
);

  fd_state_e st, st_n;
  logic [1:0] lines_s;
  logic sda_s, scl_s;
  logic [NUM_FLAGS-1:0] set_v, clr_v, flags;
  logic start_done, stop_done;
  logic start_pend, stop_pend, start_pend_n, stop_pend_n;
  logic cnt_clr, cnt_inc, cnt_last;
  logic [CW-1:0] cnt;

  // line synchronizer: bit 1 carries SDA, bit 0 carries SCL
  i2cfd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sda_in, scl_in}),
    .q     (lines_s)
  );
  assign sda_s   = lines_s[1];
  assign scl_s   = lines_s[0];
  assign sda_low = ~sda_s;
  assign scl_low = ~scl_s;

  i2cfd_pulse_cnt #(.MAX(CLR_PULSES)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt),
    .last  (cnt_last)
  );

  always_comb begin
    clr_v            = '0;
    clr_v[FLG_START] = clr_start;
    clr_v[FLG_STOP]  = clr_stop;
    clr_v[FLG_ERR]   = clr_err;
  end

  i2cfd_flags #(.N(NUM_FLAGS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .set      (set_v),
    .clr      (clr_v),
    .q        (flags)
  );
  assign flag_start = flags[FLG_START];
  assign flag_stop  = flags[FLG_STOP];
  assign flag_err   = flags[FLG_ERR];

  // next-state logic
  always_comb begin
    st_n       = st;
    set_v      = '0;
    start_done = 1'b0;
    stop_done  = 1'b0;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (!busy && start_pend) begin
          if (!scl_s) begin
            set_v[FLG_ERR]   = 1'b1;
            set_v[FLG_START] = 1'b1;
            start_done       = 1'b1;
          end else if (!sda_s) begin
            st_n    = ST_CLR_LO;
            cnt_clr = 1'b1;
          end else begin
            st_n = ST_START;
          end
        end else if (!busy && stop_pend) begin
          if (!scl_s) begin
            set_v[FLG_ERR]  = 1'b1;
            set_v[FLG_STOP] = 1'b1;
            stop_done       = 1'b1;
          end else begin
            st_n = ST_STOP;
          end
        end
      end
      ST_START: begin
        if (tick) begin
          set_v[FLG_START] = 1'b1;
          start_done       = 1'b1;
          st_n             = ST_IDLE;
        end
      end
      ST_STOP: begin
        if (tick) begin
          set_v[FLG_STOP] = 1'b1;
          stop_done       = 1'b1;
          st_n            = ST_IDLE;
        end
      end
      ST_CLR_LO: begin
        if (tick) st_n = ST_CLR_HI;
      end
      ST_CLR_HI: begin
        if (tick) begin
          cnt_inc = 1'b1;
          if (sda_s) begin
            st_n = ST_START;
          end else if (cnt_last) begin
            set_v[FLG_ERR]   = 1'b1;
            set_v[FLG_START] = 1'b1;
            start_done       = 1'b1;
            st_n             = ST_IDLE;
          end else begin
            st_n = ST_CLR_LO;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (bit_chk && sda_rel && !sda_s) set_v[FLG_ERR] = 1'b1;
    if (soft_rst) st_n = ST_IDLE;
  end

  always_comb begin
    if (soft_rst)        start_pend_n = 1'b0;
    else if (start_req)  start_pend_n = 1'b1;
    else if (start_done) start_pend_n = 1'b0;
    else                 start_pend_n = start_pend;

    if (soft_rst)        stop_pend_n = 1'b0;
    else if (stop_req)   stop_pend_n = 1'b1;
    else if (stop_done)  stop_pend_n = 1'b0;
    else                 stop_pend_n = stop_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
    end else begin
      st         <= st_n;
      start_pend <= start_pend_n;
      stop_pend  <= stop_pend_n;
    end
  end

  assign sda_oe        = (st == ST_START) || (st == ST_STOP);
  assign scl_oe        = (st == ST_CLR_LO);
  assign start_pending = start_pend;
  assign stop_pending  = stop_pend;

  // R3: a start request on a low SCL ends as error plus start flag
  a_r3_start_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start_pend && !busy && !scl_s && !soft_rst && !start_req)
    |=> (flag_err && flag_start && !start_pending && !sda_oe && !scl_oe));

  // R4: a stop request on a low SCL ends as error plus stop flag
  a_r4_stop_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && stop_pend && !start_pend && !busy && !scl_s && !soft_rst && !stop_req)
    |=> (flag_err && flag_stop && !stop_pending && !sda_oe && !scl_oe));

  // R5: a busy bus keeps the supervisor idle
  a_r5_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && busy) |=> (st == ST_IDLE && !sda_oe && !scl_oe));

  // R6, R8: SDA and SCL are never pulled at the same time
  a_r6_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_oe && scl_oe));

  // R8: SDA seen high after a pulse leads to the START
  a_r8_clear_success: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLR_HI && tick && sda_s && !soft_rst) |=> (st == ST_START));

  // R9: still low after the last pulse gives error plus start flag
  a_r9_clear_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLR_HI && tick && !sda_s && cnt_last && !soft_rst && !start_req)
    |=> (flag_err && flag_start && !start_pending && st == ST_IDLE));

  // R11: soft reset idles the block and releases both lines
  a_r11_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st == ST_IDLE && !start_pending && !stop_pending && !sda_oe && !scl_oe));

endmodule

// File: tb/i2cfd_top_test.sv
`timescale 1ns/10ps
module i2cfd_top_test;

  localparam int B_START = 8, B_STOP = 7, B_ERR = 6, B_SPEND = 5, B_PPEND = 4;
  localparam int B_SDAOE = 3, B_SCLOE = 2, B_SDALO = 1, B_SCLLO = 0;

  logic clk, rst_n, soft_rst, tick, busy, start_req, stop_req, sda_rel, bit_chk;
  logic sda_in, scl_in, clr_start, clr_stop, clr_err;
  logic sda_oe, scl_oe, flag_start, flag_stop, flag_err;
  logic start_pending, stop_pending, sda_low, scl_low;

  logic sda_force, scl_force, rel_en;
  int   rel_n, pulse_base;
  int   scl_pulses, sda_pulls, tick_div;
  logic scl_oe_q, sda_oe_q;
  int   errors, checks;

  typedef struct {
    string      req;
    int         kind;
    logic [8:0] mask;
    logic [8:0] exp;
    int         cnt_got;
    int         cnt_exp;
  } sb_item_t;
  sb_item_t sb_q[$];
  event     sb_ev;

  i2cfd_top uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(tick), .busy(busy),
    .start_req(start_req), .stop_req(stop_req), .sda_rel(sda_rel), .bit_chk(bit_chk),
    .sda_in(sda_in), .scl_in(scl_in), .clr_start(clr_start), .clr_stop(clr_stop),
    .clr_err(clr_err), .sda_oe(sda_oe), .scl_oe(scl_oe), .flag_start(flag_start),
    .flag_stop(flag_stop), .flag_err(flag_err), .start_pending(start_pending),
    .stop_pending(stop_pending), .sda_low(sda_low), .scl_low(scl_low)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // open-drain line model; the stuck target lets go during a released SCL half
  assign scl_in = !(scl_oe || scl_force);
  assign sda_in = !(sda_oe || (sda_force &&
                  !(rel_en && ((scl_pulses - pulse_base) >= rel_n) && !scl_oe)));

  // free-running half-period strobe and edge counters
  always @(posedge clk) begin
    if (!rst_n) begin
      tick_div <= 0; tick <= 1'b0;
      scl_pulses <= 0; sda_pulls <= 0; scl_oe_q <= 1'b0; sda_oe_q <= 1'b0;
    end else begin
      tick_div <= (tick_div == 7) ? 0 : tick_div + 1;
      tick     <= (tick_div == 7);
      scl_oe_q <= scl_oe;
      sda_oe_q <= sda_oe;
      if (scl_oe && !scl_oe_q) scl_pulses <= scl_pulses + 1;
      if (sda_oe && !sda_oe_q) sda_pulls  <= sda_pulls + 1;
    end
  end

  function automatic logic [8:0] obs();
    return {flag_start, flag_stop, flag_err, start_pending, stop_pending,
            sda_oe, scl_oe, sda_low, scl_low};
  endfunction

  // scoreboard monitor
  initial begin
    errors = 0; checks = 0;
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (it.kind == 0) begin
          if ((obs() & it.mask) !== (it.exp & it.mask)) begin
            errors++;
            $display("FAIL %s: got %b expected %b (mask %b)", it.req,
                     obs() & it.mask, it.exp & it.mask, it.mask);
          end
        end else if (it.cnt_got != it.cnt_exp) begin
          errors++;
          $display("FAIL %s: got count %0d expected %0d", it.req, it.cnt_got, it.cnt_exp);
        end
      end
    end
  end

  task automatic chk(string req, logic [8:0] mask, logic [8:0] exp);
    sb_item_t it;
    it = '{req: req, kind: 0, mask: mask, exp: exp, cnt_got: 0, cnt_exp: 0};
    sb_q.push_back(it);
    ->sb_ev;
    #0.1;
  endtask

  task automatic chk_cnt(string req, int got, int exp);
    sb_item_t it;
    it = '{req: req, kind: 1, mask: '0, exp: '0, cnt_got: got, cnt_exp: exp};
    sb_q.push_back(it);
    ->sb_ev;
    #0.1;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_bit(int idx, int maxc);
    for (int i = 0; i < maxc && !obs()[idx]; i++) @(negedge clk);
  endtask

  task automatic pulse_start(); start_req = 1'b1; cyc(1); start_req = 1'b0; endtask
  task automatic pulse_stop();  stop_req  = 1'b1; cyc(1); stop_req  = 1'b0; endtask
  task automatic clear_all();
    clr_start = 1'b1; clr_stop = 1'b1; clr_err = 1'b1; cyc(1);
    clr_start = 1'b0; clr_stop = 1'b0; clr_err = 1'b0; cyc(1);
  endtask

  task automatic bus_clear_case(string req, int n, logic ok);
    int p0, s0;
    sda_force = 1'b1; rel_en = ok; rel_n = n; pulse_base = scl_pulses;
    cyc(3);
    p0 = scl_pulses; s0 = sda_pulls;
    pulse_start();
    wait_bit(B_START, 600);
    cyc(1);
    chk(req, (9'b1 << B_START) | (9'b1 << B_ERR) | (9'b1 << B_SPEND) | (9'b1 << B_SCLOE),
        ok ? (9'b1 << B_START) : ((9'b1 << B_START) | (9'b1 << B_ERR)));
    chk_cnt({req, " pulses"}, scl_pulses - p0, ok ? n : 10);
    chk_cnt({req, " start drive"}, sda_pulls - s0, ok ? 1 : 0);
    sda_force = 1'b0; rel_en = 1'b0;
    cyc(3);
    clear_all();
  endtask

  initial begin
    int s0;
    rst_n = 1'b0; soft_rst = 1'b0; busy = 1'b0; start_req = 1'b0; stop_req = 1'b0;
    sda_rel = 1'b0; bit_chk = 1'b0; clr_start = 1'b0; clr_stop = 1'b0; clr_err = 1'b0;
    sda_force = 1'b0; scl_force = 1'b0; rel_en = 1'b0; rel_n = 0; pulse_base = 0;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 reset state", 9'h1FF, 9'h000);

    // R1: two-edge synchronizer latency on both lines
    sda_force = 1'b1; cyc(1);
    chk("R1 sda_low before sync", 9'b1 << B_SDALO, 9'h000);
    cyc(1);
    chk("R1 sda_low after sync", 9'b1 << B_SDALO, 9'b1 << B_SDALO);
    sda_force = 1'b0; scl_force = 1'b1; cyc(2);
    chk("R1 scl_low after sync", 9'b11, 9'b01);
    scl_force = 1'b0; cyc(3);

    // R2: high-bit check
    sda_force = 1'b1; cyc(3);
    bit_chk = 1'b1; sda_rel = 1'b0; cyc(1); bit_chk = 1'b0;
    chk("R2 no check while driving", 9'b1 << B_ERR, 9'h000);
    bit_chk = 1'b1; sda_rel = 1'b1; cyc(1); bit_chk = 1'b0;
    chk("R2 low on released SDA", 9'b1 << B_ERR, 9'b1 << B_ERR);
    sda_force = 1'b0; clear_all(); cyc(3);
    bit_chk = 1'b1; cyc(1); bit_chk = 1'b0; sda_rel = 1'b0;
    chk("R2 high on released SDA", 9'b1 << B_ERR, 9'h000);

    // R5 then R6: request waits on busy, then a clean START
    busy = 1'b1; s0 = sda_pulls;
    pulse_start(); cyc(20);
    chk("R5 held while busy", 9'h1FF, 9'b1 << B_SPEND);
    busy = 1'b0;
    wait_bit(B_START, 100);
    cyc(1);
    chk("R6 start issued", 9'h1FC, 9'b1 << B_START);
    chk_cnt("R6 one SDA pull", sda_pulls - s0, 1);
    clear_all();

    // R3: start with SCL stuck low
    scl_force = 1'b1; cyc(3);
    pulse_start(); cyc(3);
    chk("R3 start on low SCL", 9'h1FC, (9'b1 << B_START) | (9'b1 << B_ERR));
    clear_all();

    // R4: stop with SCL stuck low
    pulse_stop(); cyc(3);
    chk("R4 stop on low SCL", 9'h1FC, (9'b1 << B_STOP) | (9'b1 << B_ERR));
    scl_force = 1'b0; cyc(3); clear_all();

    // R7: clean STOP
    s0 = sda_pulls;
    pulse_stop();
    wait_bit(B_STOP, 100);
    cyc(1);
    chk("R7 stop issued", 9'h1FC, 9'b1 << B_STOP);
    chk_cnt("R7 one SDA pull", sda_pulls - s0, 1);
    clear_all();

    // R8, R9: bus clearing
    bus_clear_case("R8 clear after 3", 3, 1'b1);
    bus_clear_case("R8 clear after 9", 9, 1'b1);
    bus_clear_case("R9 clear fails", 0, 1'b0);

    // R10: stickiness, per-flag clear, set wins over clear
    scl_force = 1'b1; cyc(3); pulse_start(); cyc(3); scl_force = 1'b0; cyc(3);
    clr_err = 1'b1; cyc(1); clr_err = 1'b0; cyc(1);
    chk("R10 only error cleared", (9'b1 << B_START) | (9'b1 << B_ERR), 9'b1 << B_START);
    cyc(10);
    chk("R10 start flag sticky", 9'b1 << B_START, 9'b1 << B_START);
    sda_force = 1'b1; cyc(3);
    sda_rel = 1'b1; bit_chk = 1'b1; clr_err = 1'b1; cyc(1);
    sda_rel = 1'b0; bit_chk = 1'b0; clr_err = 1'b0;
    chk("R10 set beats clear", 9'b1 << B_ERR, 9'b1 << B_ERR);
    sda_force = 1'b0; cyc(3); clear_all();

    // R11: soft reset in the middle of bus clearing
    sda_force = 1'b1; rel_en = 1'b0; cyc(3);
    sda_rel = 1'b1; bit_chk = 1'b1; cyc(1); sda_rel = 1'b0; bit_chk = 1'b0;
    pulse_stop();
    busy = 1'b1; pulse_start(); busy = 1'b0;
    cyc(20);
    soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
    chk("R11 soft reset", 9'h1FE, 9'b1 << B_SDALO);
    s0 = scl_pulses;
    cyc(40);
    chk("R11 stays idle", 9'h1FC, 9'h000);
    chk_cnt("R11 no further pulses", scl_pulses - s0, 0);
    sda_force = 1'b0; cyc(3);

    cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule